// File: doc/BRIEF.md
# Scatter-Gather Descriptor Sequencer

This block runs a chain of up to 32 transfer descriptors, one after another, in front of a single-transfer engine. Each descriptor holds a transfer mode (fill, write, read or copy), a byte length, a source address, a destination address, a fill byte and an end-of-chain flag. Software does not address the descriptor table directly. It writes an item number into an index register, and a small window of field registers then reads and writes that item's fields.

A settings register holds an enable bit and a go bit. When go is accepted, the sequencer starts at item 0. For each item it latches the item's fields onto the engine outputs and gives a one-cycle start pulse. It then waits for the engine's done pulse before it moves to the next item. The chain ends after the item whose end flag is set, or after the highest item if no flag is set. At that point go drops, a sticky done flag rises, and the interrupt line follows the done flag when the interrupt enable input is high.

While a chain runs, the sequencer locks the table and the settings register against writes, so a running task cannot be changed or restarted.

Top module: `sg_chain_seq`

## Requirements
- R1: After reset, every register read (cfgAddr 0 to 6) returns 0, engStart is low and irq is low.
- R2: cfgAddr 0 is the item index, written and read from bits [4:0]; higher write bits are dropped. The window registers act on the item the index selects. They are cfgAddr 1 (mode in bits [1:0], with 0 fill, 1 write, 2 read, 3 copy; end-of-chain flag in bit 8), cfgAddr 2 (length, bits [24:0]), cfgAddr 3 (source, bits [30:0]), cfgAddr 4 (destination, bits [30:0]) and cfgAddr 5 (fill byte, bits [7:0]). Unused read bits return 0.
- R3: While go is high, writes to cfgAddr 1 to 5 leave the table unchanged. Index writes still take effect.
- R4: cfgAddr 6 is the settings register: bit 0 enable, bit 1 go, bit 2 done (read only). A go request is accepted only when the same write sets bit 0 and bit 1 together. A write with bit 1 set and bit 0 clear leaves go low and starts nothing.
- R5: engStart is a single-cycle pulse. It rises in the cycle after go is accepted and in the cycle after each non-final accepted done. While it is high, engMode, engLength, engSrc, engDst and engFill carry the fields of the item being run. Items run from 0 upward.
- R6: An engDone pulse counts only after the start pulse of the current item. A pulse while idle, or in the same cycle as engStart, has no effect.
- R7: When the accepted done belongs to an item whose end flag is set, go drops and done rises in the next cycle, and no further start is issued.
- R8: If no item has its end flag set, the chain runs all 32 items and ends after item 31.
- R9: irq is high exactly when the done flag is set and irqEnable is high. The done flag clears when a new go is accepted.
- R10: While go is high, writes to the settings register are ignored. This includes a go write in the same cycle as the final done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select for both reads and writes |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Read data of the selected register (combinational) |
| irqEnable | input | 1 | Lets the done flag drive irq |
| irq | output | 1 | Chain-complete interrupt |
| engStart | output | 1 | Start pulse to the transfer engine |
| engMode | output | 2 | Mode of the item being run |
| engLength | output | 25 | Byte length of the item being run |
| engSrc | output | 31 | Source address of the item being run |
| engDst | output | 31 | Destination address of the item being run |
| engFill | output | 8 | Fill byte of the item being run |
| engDone | input | 1 | Done pulse from the transfer engine |

## Verification
Two collisions are provoked on purpose. In the first, the engine's final done pulse arrives in the same cycle as a software write of a new go. The bench engine model issues that settings write together with the last done pulse, and the result is judged by go ending low, done ending high and no new start pulse appearing. In the second, a done pulse lands in the same cycle as a start pulse, and table and settings writes are issued while a chain runs. A behavioural model compares engStart, irq, the selected register and the engine fields on every cycle. Read-back and start counts after each run confirm that none of these stray events had any effect.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Register selector values on cfgAddr
  typedef enum logic [2:0] {
    REG_INDEX    = 3'd0,
    REG_CONFIG   = 3'd1,
    REG_LENGTH   = 3'd2,
    REG_SRC      = 3'd3,
    REG_DST      = 3'd4,
    REG_FILL     = 3'd5,
    REG_SETTINGS = 3'd6
  } regSel_e;

  typedef enum logic [1:0] {
    XFER_FILL  = 2'd0,
    XFER_WRITE = 2'd1,
    XFER_READ  = 2'd2,
    XFER_COPY  = 2'd3
  } xferMode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seqState_e;

  localparam int LAST_BIT     = 8;
  localparam int SET_EN_BIT   = 0;
  localparam int SET_GO_BIT   = 1;
  localparam int SET_DONE_BIT = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic tableLock;  // chain running: table writes blocked
    logic launch;     // latch item fields onto engine outputs
  } seqStrobe_t;

endpackage

// File: rtl/sg_table.sv
module sg_table
  import sg_pkg::*;
#(
  parameter int NUM_ITEMS = 32,
  parameter int LEN_W     = 25,
  parameter int ADDR_W    = 31,
  parameter int FILL_W    = 8,
  parameter int IDX_W     = $clog2(NUM_ITEMS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  launchIdx,
  input  logic [IDX_W-1:0]  curIdx,
  output logic [31:0]       winRdData,
  output logic              curLast,
  output logic [1:0]        engMode,
  output logic [LEN_W-1:0]  engLength,
  output logic [ADDR_W-1:0] engSrc,
  output logic [ADDR_W-1:0] engDst,
  output logic [FILL_W-1:0] engFill
);

  logic [IDX_W-1:0]  selIdx;
  logic [1:0]        modeMem [NUM_ITEMS];
  logic              lastMem [NUM_ITEMS];
  logic [LEN_W-1:0]  lenMem  [NUM_ITEMS];
  logic [ADDR_W-1:0] srcMem  [NUM_ITEMS];
  logic [ADDR_W-1:0] dstMem  [NUM_ITEMS];
  logic [FILL_W-1:0] fillMem [NUM_ITEMS];
  logic [NUM_ITEMS-1:0] itemWr;
  logic unusedWrBits;

  assign unusedWrBits = ^cfgWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selIdx <= '0;
    else if (cfgWrEn && cfgAddr == REG_INDEX) selIdx <= cfgWrData[IDX_W-1:0];
  end

  // Per-item write decode
  for (genvar i = 0; i < NUM_ITEMS; i++) begin : gItemDec
    assign itemWr[i] = cfgWrEn && !strobe.tableLock && (selIdx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    for (int i = 0; i < NUM_ITEMS; i++) begin
      if (!rstN) begin
        modeMem[i] <= '0;
        lastMem[i] <= 1'b0;
        lenMem[i]  <= '0;
        srcMem[i]  <= '0;
        dstMem[i]  <= '0;
        fillMem[i] <= '0;
      end else if (itemWr[i]) begin
        case (cfgAddr)
          REG_CONFIG: begin
            modeMem[i] <= cfgWrData[1:0];
            lastMem[i] <= cfgWrData[LAST_BIT];
          end
          REG_LENGTH: lenMem[i]  <= cfgWrData[LEN_W-1:0];
          REG_SRC:    srcMem[i]  <= cfgWrData[ADDR_W-1:0];
          REG_DST:    dstMem[i]  <= cfgWrData[ADDR_W-1:0];
          REG_FILL:   fillMem[i] <= cfgWrData[FILL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Window read of the selected item
  always_comb begin
    winRdData = '0;
    case (cfgAddr)
      REG_INDEX:  winRdData = 32'(selIdx);
      REG_CONFIG: begin
        winRdData[1:0]      = modeMem[selIdx];
        winRdData[LAST_BIT] = lastMem[selIdx];
      end
      REG_LENGTH: winRdData = 32'(lenMem[selIdx]);
      REG_SRC:    winRdData = 32'(srcMem[selIdx]);
      REG_DST:    winRdData = 32'(dstMem[selIdx]);
      REG_FILL:   winRdData = 32'(fillMem[selIdx]);
      default:    winRdData = '0;
    endcase
  end

  // Engine fields, latched when an item is launched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engMode   <= '0;
      engLength <= '0;
      engSrc    <= '0;
      engDst    <= '0;
      engFill   <= '0;
    end else if (strobe.launch) begin
      engMode   <= modeMem[launchIdx];
      engLength <= lenMem[launchIdx];
      engSrc    <= srcMem[launchIdx];
      engDst    <= dstMem[launchIdx];
      engFill   <= fillMem[launchIdx];
    end
  end

  assign curLast = lastMem[curIdx];

endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int NUM_ITEMS = 32,
  parameter int IDX_W     = $clog2(NUM_ITEMS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgAddr,
  input  logic [1:0]       setBits,
  input  logic             engDone,
  input  logic             curLast,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] launchIdx,
  output logic [IDX_W-1:0] curIdx,
  output logic             engStart,
  output logic             goBit,
  output logic             enBit,
  output logic             doneFlag
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ITEMS - 1);

  seqState_e state;
  logic wrSettings, accept, stepOk, finalItem, advance, finish;

  assign wrSettings = cfgWrEn && (cfgAddr == REG_SETTINGS);
  assign accept     = (state == ST_IDLE) && wrSettings &&
                      setBits[SET_EN_BIT] && setBits[SET_GO_BIT];
  assign stepOk     = (state == ST_WAIT) && engDone;
  assign finalItem  = curLast || (curIdx == LAST_IDX);
  assign advance    = stepOk && !finalItem;
  assign finish     = stepOk && finalItem;
  assign launchIdx  = accept ? '0 : curIdx + 1'b1;

  always_comb begin
    strobe.tableLock = (state != ST_IDLE);
    strobe.launch    = accept || advance;
  end

  assign engStart = (state == ST_LAUNCH);
  assign goBit    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curIdx   <= '0;
      enBit    <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (wrSettings && state == ST_IDLE) enBit <= setBits[SET_EN_BIT];
      if (strobe.launch) curIdx <= launchIdx;
      if (accept) doneFlag <= 1'b0;
      else if (finish) doneFlag <= 1'b1;
      case (state)
        ST_IDLE:   if (accept) state <= ST_LAUNCH;
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (advance) state <= ST_LAUNCH;
          else if (finish) state <= ST_IDLE;
        end
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sg_chain_seq.sv
module sg_chain_seq
  import sg_pkg::*;
#(
  parameter int NUM_ITEMS = 32,
  parameter int LEN_W     = 25,
  parameter int ADDR_W    = 31,
  parameter int FILL_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  input  logic              irqEnable,
  output logic              irq,
  output logic              engStart,
  output logic [1:0]        engMode,
  output logic [LEN_W-1:0]  engLength,
  output logic [ADDR_W-1:0] engSrc,
  output logic [ADDR_W-1:0] engDst,
  output logic [FILL_W-1:0] engFill,
  input  logic              engDone
);

  localparam int IDX_W = $clog2(NUM_ITEMS);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] launchIdx, curIdx;
  logic [31:0]      winRdData;
  logic             curLast, goBit, enBit, doneFlag;

  sg_ctrl #(.NUM_ITEMS(NUM_ITEMS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .setBits(cfgWrData[1:0]), .engDone(engDone), .curLast(curLast),
    .strobe(strobe), .launchIdx(launchIdx), .curIdx(curIdx),
    .engStart(engStart), .goBit(goBit), .enBit(enBit), .doneFlag(doneFlag)
  );

  sg_table #(.NUM_ITEMS(NUM_ITEMS), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
             .FILL_W(FILL_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .strobe(strobe), .launchIdx(launchIdx),
    .curIdx(curIdx), .winRdData(winRdData), .curLast(curLast),
    .engMode(engMode), .engLength(engLength), .engSrc(engSrc),
    .engDst(engDst), .engFill(engFill)
  );

  always_comb begin
    if (cfgAddr == REG_SETTINGS) begin
      cfgRdData = '0;
      cfgRdData[SET_EN_BIT]   = enBit;
      cfgRdData[SET_GO_BIT]   = goBit;
      cfgRdData[SET_DONE_BIT] = doneFlag;
    end else begin
      cfgRdData = winRdData;
    end
  end

  assign irq = doneFlag && irqEnable;

endmodule

// File: rtl/sg_chain_chk.sv
module sg_chain_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [2:0]       cfgAddr,
  input logic [1:0]       setBits,
  input logic             engStart,
  input logic             engDone,
  input logic             goBit,
  input logic             doneFlag,
  input logic             irq,
  input logic             irqEnable,
  input logic [IDX_W-1:0] curIdx
);

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R5
  start_in_task_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> goBit);

  // R5
  first_item_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBit) |-> (engStart && curIdx == '0));

  // R6
  advance_on_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !$rose(goBit)) |-> $past(engDone));

  // R8
  index_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !$rose(goBit)) |-> (curIdx == IDX_W'($past(curIdx) + 1'b1)));

  // R7
  finish_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(goBit) |-> (doneFlag && $past(engDone)));

  // R4
  go_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(goBit) |-> $past(cfgWrEn && cfgAddr == 3'd6 && setBits == 2'b11));

  // R9
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (doneFlag && irqEnable));

endmodule

bind sg_chain_seq sg_chain_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .setBits(cfgWrData[1:0]), .engStart(engStart), .engDone(engDone),
  .goBit(goBit), .doneFlag(doneFlag), .irq(irq), .irqEnable(irqEnable),
  .curIdx(curIdx)
);

// File: tb/sim_sg_chain_seq.sv
module sim_sg_chain_seq;

  localparam int N = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rstN, cfgWrEn, irqEnable, irq, engStart, engDone;
  logic [2:0] cfgAddr;
  logic [31:0] cfgWrData, cfgRdData;
  logic [1:0] engMode;
  logic [24:0] engLength;
  logic [30:0] engSrc, engDst;
  logic [7:0] engFill;

  sg_chain_seq u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .irqEnable(irqEnable),
    .irq(irq), .engStart(engStart), .engMode(engMode), .engLength(engLength),
    .engSrc(engSrc), .engDst(engDst), .engFill(engFill), .engDone(engDone)
  );

  int nChecks = 0, nFail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]  mMode [N];
  logic        mLast [N];
  logic [24:0] mLen  [N];
  logic [30:0] mSrc  [N];
  logic [30:0] mDst  [N];
  logic [7:0]  mFill [N];
  int mIdx, mCur, mState;  // state: 0 idle, 1 start cycle, 2 waiting
  bit mGo, mEn, mDone;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mMode[i] = 0; mLast[i] = 0; mLen[i] = 0; mSrc[i] = 0; mDst[i] = 0; mFill[i] = 0;
      end
      mIdx = 0; mCur = 0; mState = 0; mGo = 0; mEn = 0; mDone = 0;
    end else begin
      if (cfgWrEn && cfgAddr == 3'd0) mIdx = int'(cfgWrData[4:0]);
      else if (cfgWrEn && !mGo) begin
        case (cfgAddr)
          3'd1: begin mMode[mIdx] = cfgWrData[1:0]; mLast[mIdx] = cfgWrData[8]; end
          3'd2: mLen[mIdx]  = cfgWrData[24:0];
          3'd3: mSrc[mIdx]  = cfgWrData[30:0];
          3'd4: mDst[mIdx]  = cfgWrData[30:0];
          3'd5: mFill[mIdx] = cfgWrData[7:0];
          default: ;
        endcase
      end
      case (mState)
        0: if (cfgWrEn && cfgAddr == 3'd6) begin
             mEn = cfgWrData[0];
             if (cfgWrData[1:0] == 2'b11) begin mGo = 1; mDone = 0; mCur = 0; mState = 1; end
           end
        1: mState = 2;
        default: if (engDone) begin
             if (mLast[mCur] || mCur == N - 1) begin mGo = 0; mDone = 1; mState = 0; end
             else begin mCur++; mState = 1; end
           end
      endcase
    end
  end

  function automatic logic [31:0] expRd(input logic [2:0] a);
    case (a)
      3'd0: return 32'(mIdx);
      3'd1: return {23'd0, mLast[mIdx], 6'd0, mMode[mIdx]};
      3'd2: return 32'(mLen[mIdx]);
      3'd3: return 32'(mSrc[mIdx]);
      3'd4: return 32'(mDst[mIdx]);
      3'd5: return 32'(mFill[mIdx]);
      3'd6: return {29'd0, mDone, mGo, mEn};
      default: return 32'd0;
    endcase
  endfunction

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(engStart == (mState == 1), "R5/R6 engStart", 32'(engStart), 32'(mState == 1));
      chk(cfgRdData == expRd(cfgAddr), "R2/R3 register read", cfgRdData, expRd(cfgAddr));
      chk(irq == (mDone && irqEnable), "R9 irq", 32'(irq), 32'(mDone && irqEnable));
      if (mState == 1) begin
        chk(engMode == mMode[mCur], "R5 engMode", 32'(engMode), 32'(mMode[mCur]));
        chk(engLength == mLen[mCur], "R5 engLength", 32'(engLength), 32'(mLen[mCur]));
        chk(engSrc == mSrc[mCur], "R5 engSrc", 32'(engSrc), 32'(mSrc[mCur]));
        chk(engDst == mDst[mCur], "R5 engDst", 32'(engDst), 32'(mDst[mCur]));
        chk(engFill == mFill[mCur], "R5 engFill", 32'(engFill), 32'(mFill[mCur]));
      end
    end
  end

  // ---------------- engine responder ----------------
  bit respOn = 0, spur = 0, coGo = 0;
  int respLat = 1, startCount = 0, coTarget = 0;

  initial forever begin
    @(negedge clk);
    if (respOn && engStart) begin
      startCount++;
      if (spur) engDone = 1'b1;  // same cycle as start: must be ignored (R6)
      repeat (respLat) begin @(posedge clk); #1 engDone = 1'b0; end
      engDone = 1'b1;
      if (coGo && startCount == coTarget) begin
        cfgWrEn = 1'b1; cfgAddr = 3'd6; cfgWrData = 32'h3;  // collides with final done (R10)
      end
      @(posedge clk); #1;
      engDone = 1'b0;
      if (coGo && startCount == coTarget) begin cfgWrEn = 1'b0; end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; cfgAddr = 3'd6;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfgAddr = a;
    @(negedge clk);
    chk(cfgRdData == exp, tag, cfgRdData, exp);
  endtask

  task automatic waitIdle();
    int k = 0;
    do begin @(negedge clk); k++; end while (mGo && k < 5000);
    chk(!mGo, "R7 chain terminates", 32'(mGo), 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog R7 act=running exp=finished");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgAddr = 3'd6; cfgWrData = '0;
    irqEnable = 1'b1; engDone = 1'b0;
    repeat (3) @(posedge clk); #1 rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 7; a++) rdChk(3'(a), 32'd0, "R1 reset read");
    @(negedge clk);
    chk(engStart == 1'b0, "R1 engStart after reset", 32'(engStart), 0);
    chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);

    // Program items 0..3, item 2 marked last
    for (int i = 0; i < 4; i++) begin
      wrReg(3'd0, 32'(i));
      wrReg(3'd1, 32'(i % 4) | ((i == 2) ? 32'h100 : 32'h0));
      wrReg(3'd2, 32'd100 + 32'(i));
      wrReg(3'd3, 32'h1000_0000 + 32'(i * 16));
      wrReg(3'd4, 32'h2000_0040 + 32'(i));
      wrReg(3'd5, 32'hFFFF_FFA0 + 32'(i));
    end

    // R2: window follows index
    wrReg(3'd0, 32'd1);
    rdChk(3'd1, 32'h1, "R2 item1 config");
    rdChk(3'd2, 32'd101, "R2 item1 length");
    rdChk(3'd3, 32'h1000_0010, "R2 item1 src");
    rdChk(3'd5, 32'hA1, "R2 item1 fill (8 bits)");
    wrReg(3'd0, 32'h22);
    rdChk(3'd0, 32'h2, "R2 index masks to 5 bits");
    rdChk(3'd1, 32'h102, "R2 item2 config with last flag");

    // R4: go without enable is refused
    wrReg(3'd6, 32'h2);
    repeat (3) @(negedge clk);
    rdChk(3'd6, 32'h0, "R4 go without enable refused");
    wrReg(3'd6, 32'h1);
    rdChk(3'd6, 32'h1, "R4 enable alone");

    // R5/R7: run chain, last at item 2
    respOn = 1; respLat = 3; startCount = 0;
    wrReg(3'd6, 32'h3);
    waitIdle();
    chk(startCount == 3, "R7 three items run", 32'(startCount), 3);
    rdChk(3'd6, 32'h5, "R7 done set, go clear");
    chk(irq == 1'b1, "R9 irq with enable", 32'(irq), 1);

    // R3/R10/R9: writes during a run
    wrReg(3'd0, 32'd0);
    respLat = 8; startCount = 0;
    wrReg(3'd6, 32'h3);
    rdChk(3'd6, 32'h3, "R9 done cleared on new go");
    wrReg(3'd2, 32'h1FFFF);   // ignored
    wrReg(3'd6, 32'h3);       // ignored
    waitIdle();
    chk(startCount == 3, "R10 no restart during run", 32'(startCount), 3);
    rdChk(3'd2, 32'd100, "R3 table write ignored while running");

    // R6: done in start cycle and while idle
    spur = 1; startCount = 0;
    wrReg(3'd6, 32'h3);
    waitIdle();
    spur = 0;
    chk(startCount == 3, "R6 early done ignored", 32'(startCount), 3);
    @(posedge clk); #1 engDone = 1'b1;
    @(posedge clk); #1 engDone = 1'b0;
    repeat (3) @(negedge clk);
    chk(startCount == 3, "R6 idle done ignored", 32'(startCount), 3);
    rdChk(3'd6, 32'h5, "R6 idle done leaves settings");

    // R8: no last flag anywhere -> 32 items
    wrReg(3'd0, 32'd2);
    wrReg(3'd1, 32'h2);
    respLat = 1; startCount = 0;
    wrReg(3'd6, 32'h3);
    waitIdle();
    chk(startCount == 32, "R8 runs to item 31", 32'(startCount), 32);

    // R10: go write in the same cycle as the final done
    wrReg(3'd1, 32'h102);
    coGo = 1; coTarget = 3; startCount = 0; respLat = 2;
    wrReg(3'd6, 32'h3);
    waitIdle();
    coGo = 0;
    repeat (4) @(negedge clk);
    chk(startCount == 3, "R10 collision no restart", 32'(startCount), 3);
    rdChk(3'd6, 32'h5, "R10 collision leaves go low, done high");

    // R9: irq masked
    @(posedge clk); #1 irqEnable = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq masked", 32'(irq), 0);

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule